// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block derives the SCL clock of an I2C master from the system clock. A programmable timing word carries three fields: a power-of-two prescaler exponent, a high-phase count and a low-phase count. The prescaler makes a base tick every 2^exp system clocks. SCL is then held low for (low count + 1) base ticks and high for (high count + 1) base ticks, so one SCL period lasts 2^exp × (high + 1 + low + 1) system clocks.

The byte engine next to it gets two one-cycle strobes. One marks the first cycle of each low phase, where SDA may change. The other marks the middle of each high phase, where SDA is sampled. A timing word is taken in only when a low phase begins, so a period in progress always finishes with the values it started with. When the enable is low, SCL is released and all counters sit at zero.

The high and low fields are HL_W bits wide. The default is 4 bits, which allows up to 32 base ticks per period. Setting HL_W to 3 gives a narrower variant with at most 16 base ticks per period.

Top module: `scl_timer`

## Requirements
- R1: While `en` is low, and in the reset state, `scl_o` is 1 and both strobes are 0 in every cycle.
- R2: Each low phase lasts exactly (lo + 1) × 2^div system clocks of `scl_o` = 0.
- R3: Each high phase lasts exactly (hi + 1) × 2^div system clocks of `scl_o` = 1.
- R4: Field positions: div is `timing_word[3:0]` (0 to 15), lo is `timing_word[15:12]` and hi is `timing_word[19:16]`, each stored as its count minus one. Bits 31:20 and 11:4 have no effect on the output.
- R5: A timing word is captured only in the cycle a low phase starts. A change to the word part way through a period leaves that period's low and high lengths unchanged, and it governs the next period.
- R6: `low_stb` is high for exactly one cycle per period: the first cycle in which `scl_o` is 0.
- R7: `sample_stb` is high for exactly one cycle per period. That cycle is in the high phase, floor(H/2) cycles after the first high cycle, where H is the high-phase length.
- R8: When `en` is first seen high at a clock edge, `scl_o` goes to 0 with `low_stb` on that same edge, and a full low phase follows.
- R9: Lowering `en` releases `scl_o` on the next edge, even mid-phase. Raising it again starts over from a fresh low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; low releases SCL and clears the counters |
| timing_word | input | WORD_W | Prescaler exponent, high count and low count fields |
| scl_o | output | 1 | SCL level to drive (1 = released) |
| low_stb | output | 1 | One-cycle pulse at the start of each low phase |
| sample_stb | output | 1 | One-cycle pulse at the middle of each high phase |

## Verification
The assertions take for granted that `en` and `timing_word` change only between clock edges. They also assume the design has spent at least one cycle in reset before it runs, so that the held timing fields and the phase state start from known values. The bench drives every input on the falling edge and samples outputs there too. It sweeps all high and low counts for the three smallest exponents, and then checks a larger exponent, stray upper-bit content, a mid-period word change and enable toggling.

// File: rtl/scl_timer.sv
module scl_timer #(
  parameter int HL_W   = 4,
  parameter int DIV_W  = 4,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [WORD_W-1:0] timing_word,
  output logic              scl_o,
  output logic              low_stb,
  output logic              sample_stb
);
  localparam int PRE_W = (1 << DIV_W) - 1;
  localparam int EL_W  = HL_W + PRE_W + 1;
  localparam int HI_LSB = 16;
  localparam int LO_LSB = 12;

  logic             running, phase;
  logic [DIV_W-1:0] act_div;
  logic [HL_W-1:0]  act_hi, act_lo, ph_cnt;
  logic [PRE_W-1:0] pre_cnt;

  wire [DIV_W-1:0] w_div = timing_word[DIV_W-1:0];
  wire [HL_W-1:0]  w_hi  = timing_word[HI_LSB +: HL_W];
  wire [HL_W-1:0]  w_lo  = timing_word[LO_LSB +: HL_W];

  wire [PRE_W-1:0] pre_mask = ~({PRE_W{1'b1}} << act_div);
  wire             tick     = (pre_cnt == pre_mask);
  wire             ph_end   = (ph_cnt == (phase ? act_hi : act_lo));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      phase   <= 1'b0;
      ph_cnt  <= '0;
      pre_cnt <= '0;
      act_div <= '0;
      act_hi  <= '0;
      act_lo  <= '0;
    end else if (!en) begin
      running <= 1'b0;
      phase   <= 1'b0;
      ph_cnt  <= '0;
      pre_cnt <= '0;
    end else if (!running) begin
      running <= 1'b1;
      phase   <= 1'b0;
      ph_cnt  <= '0;
      pre_cnt <= '0;
      act_div <= w_div;
      act_hi  <= w_hi;
      act_lo  <= w_lo;
    end else if (tick) begin
      pre_cnt <= '0;
      if (ph_end) begin
        ph_cnt <= '0;
        phase  <= ~phase;
        if (phase) begin
          act_div <= w_div;
          act_hi  <= w_hi;
          act_lo  <= w_lo;
        end
      end else begin
        ph_cnt <= ph_cnt + 1'b1;
      end
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  wire [EL_W-1:0] elapsed = (EL_W'(ph_cnt) << act_div) | EL_W'(pre_cnt);
  wire [EL_W-1:0] mid_pt  = ((EL_W'(act_hi) + EL_W'(1)) << act_div) >> 1;

  assign scl_o      = ~running | phase;
  assign low_stb    = running & ~phase & (ph_cnt == '0) & (pre_cnt == '0);
  assign sample_stb = running & phase & (elapsed == mid_pt);

  p_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (scl_o && !low_stb && !sample_stb));

  p_lowstb_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    low_stb |=> !low_stb);

  p_fall_marks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_o) |-> low_stb);

  p_sample_in_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> scl_o);

  p_word_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !low_stb) |-> ($stable(act_div) && $stable(act_hi) && $stable(act_lo)));

  p_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !running) |=> (low_stb && !scl_o));
endmodule

// File: tb/scl_timer_bench.sv
module scl_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [31:0] word = '0;
  logic        scl_o, low_stb, sample_stb;
  int          n_chk = 0;
  int          n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scl_timer u_scl_timer (
    .clk(clk), .rst_n(rst_n), .en(en), .timing_word(word),
    .scl_o(scl_o), .low_stb(low_stb), .sample_stb(sample_stb)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cfg(input int d, input int h, input int l);
    return (32'(h) << 16) | (32'(l) << 12) | 32'(d);
  endfunction

  task automatic wait_low();
    do @(negedge clk); while (!low_stb);
  endtask

  // Starts at a sample where low_stb is 1; ends at the next such sample.
  task automatic measure(input int d, input int h, input int l, input string tag,
                         input int change_at, input logic [31:0] new_word);
    int lcnt = 0, hcnt = 0, sidx = -1, scount = 0, lscount = 0, bad_samp = 0;
    int e_l = (l + 1) << d;
    int e_h = (h + 1) << d;
    while (scl_o == 1'b0) begin
      if (low_stb) lscount++;
      if (sample_stb) bad_samp++;
      lcnt++;
      if (lcnt == change_at) word = new_word;
      @(negedge clk);
    end
    while (scl_o == 1'b1 && !low_stb) begin
      if (low_stb) lscount++;
      if (sample_stb) begin scount++; sidx = hcnt; end
      hcnt++;
      @(negedge clk);
    end
    chk(lcnt == e_l, {"R2 low length ", tag}, lcnt, e_l);
    chk(hcnt == e_h, {"R3 high length ", tag}, hcnt, e_h);
    chk(lscount == 1, {"R6 low strobe count ", tag}, lscount, 1);
    chk(scount == 1 && bad_samp == 0, {"R7 sample strobe count ", tag}, scount + bad_samp, 1);
    chk(sidx == e_h / 2, {"R7 sample position ", tag}, sidx, e_h / 2);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(scl_o && !low_stb && !sample_stb, "R1 reset state", {scl_o, low_stb, sample_stb}, 3'b100);
    rst_n = 1'b1;
    word = cfg(0, 1, 1);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(scl_o && !low_stb && !sample_stb, "R1 disabled", {scl_o, low_stb, sample_stb}, 3'b100);
    end

    word = cfg(1, 2, 3);
    en = 1'b1;
    @(negedge clk);
    chk(!scl_o && low_stb, "R8 first low on enable", {scl_o, low_stb}, 2'b01);
    measure(1, 2, 3, "R8 first period", -1, '0);

    for (int d = 0; d < 3; d++)
      for (int h = 0; h < 16; h++)
        for (int l = 0; l < 16; l++) begin
          word = cfg(d, h, l);
          wait_low();
          measure(d, h, l, "sweep", -1, '0);
        end

    word = 32'hFFF0_0FF0 | cfg(2, 5, 9);
    wait_low();
    measure(2, 5, 9, "R4 upper bits ignored", -1, '0);
    word = 32'h5A50_0A50 | cfg(9, 0, 1);
    wait_low();
    measure(9, 0, 1, "R4 large prescaler", -1, '0);

    word = cfg(0, 3, 3);
    wait_low();
    measure(0, 3, 3, "R5 old word kept", 2, cfg(1, 1, 2));
    measure(1, 1, 2, "R5 new word next period", -1, '0);

    word = cfg(1, 2, 3);
    wait_low();
    measure(1, 2, 3, "R9 pre", -1, '0);
    @(negedge clk);
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(scl_o && !low_stb, "R9 release mid phase", {scl_o, low_stb}, 2'b10);
    repeat (5) begin
      @(negedge clk);
      chk(scl_o && !low_stb && !sample_stb, "R1 R9 held released", {scl_o, low_stb, sample_stb}, 3'b100);
    end
    en = 1'b1;
    @(negedge clk);
    chk(!scl_o && low_stb, "R9 restart low", {scl_o, low_stb}, 2'b01);
    measure(1, 2, 3, "R9 restart period", -1, '0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule